// File: doc/BRIEF.md
# Two-Level Page Table Walker

When the translation buffer misses, this block walks a two-level page table in memory and resolves the virtual address. It returns either a leaf entry for the buffer to install or a page fault. A walk begins with a request that carries a 32-bit virtual address and the root table's physical page number. The block then issues up to two 32-bit entry reads through a memory read port. Only one read is outstanding at a time. When the walk ends, the block raises a single-cycle response. The response carries the 22-bit physical page number, the low eight entry flag bits, a superpage flag and a fault flag.

A first-level entry with V set and R, W and X all clear is a pointer to a second-level table. A first-level entry with any of R, W or X set is a 4 MiB superpage. For a superpage the low ten bits of the page number come from the virtual address. The block has no accessed/dirty update and no disk handling. It holds one walk at a time, and a new request waits until the current response has been delivered.

Top module: `pt_walker2`

## Requirements
- R1: After reset, req_ready is 1 and both mem_req_valid and resp_valid are 0.
- R2: The first read of a walk goes to byte address (root_ppn << 12) + (vaddr[31:22] << 2). The address is 34 bits wide, and the root is sampled when the request is accepted.
- R3: Entry bit layout: bit0 V, bit1 R, bit2 W, bit3 X, bit4 U, bit5 G, bit6 A, bit7 D, bits 9:8 software, bits 31:10 page number, of which bits 19:10 are the low part. A first-level entry with V=1 and bits 3:1 all zero makes the second read go to (entry[31:10] << 12) + (vaddr[21:12] << 2).
- R4: A second-level entry with V=1 and any of bits 3:1 set completes the walk with resp_ppn = entry[31:10], resp_flags = entry[7:0], resp_super = 0 and resp_fault = 0.
- R5: A first-level entry with V=1, any of bits 3:1 set and entry[19:10] = 0 completes the walk with resp_super = 1, resp_ppn = {entry[31:20], vaddr[21:12]}, resp_flags = entry[7:0] and no fault.
- R6: A first-level leaf whose entry[19:10] is nonzero is a misaligned superpage and is reported as a fault.
- R7: An entry with V=0 at either level ends the walk with resp_fault = 1. Every fault response has resp_ppn = 0, resp_flags = 0 and resp_super = 0.
- R8: A second-level entry with V=1 and bits 3:1 all zero is reported as a fault.
- R9: req_ready is low from the cycle after a request is accepted until the cycle after its response. A req_valid, vaddr or root change seen while busy has no effect on the walk in flight.
- R10: Each accepted request yields exactly one resp_valid pulse, one cycle long. While mem_req_valid waits on mem_req_ready, mem_req_addr holds steady.
- R11: At most one memory read is outstanding. mem_rsp_ready is high only while a read is outstanding, and mem_req_valid never rises in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| root_ppn | input | 22 | Physical page number of the first-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Walk result, one cycle |
| resp_ppn | output | 22 | Translated physical page number |
| resp_flags | output | 8 | Entry flag bits D..V of the leaf |
| resp_super | output | 1 | Leaf found at the first level |
| resp_fault | output | 1 | Page fault |

## Verification
The bench builds the walker with the package defaults: 32-bit entries, 10-bit indices and 12-bit offsets. With these values, every index lands in a sparse memory image, and the bench can place leaves, pointers and misaligned superpages at both levels. A reference model computes each expected result from the same image. The memory model adds a variable read latency and a stalling request-ready pattern. Those reach the address-hold and single-outstanding cases, and requests repeated during a walk reach the ignore-while-busy case.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int VA_W   = 32;
  parameter int OFF_W  = 12;
  parameter int IDX_W  = 10;
  parameter int PTE_W  = 32;
  parameter int FLAG_W = 8;
  parameter int SW_W   = 2;
  parameter int ENT_SH = 2;  // log2 of entry bytes

  localparam int PPN_W  = PTE_W - FLAG_W - SW_W;
  localparam int PPN0_W = IDX_W;
  localparam int PPN1_W = PPN_W - PPN0_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int PPN_LO = FLAG_W + SW_W;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]  pte,
  output logic              is_valid,
  output logic              is_ptr,
  output logic              is_leaf,
  output logic              low_nz,
  output logic [PPN_W-1:0]  ppn,
  output logic [FLAG_W-1:0] flags
);
  logic [2:0]      rwx;
  logic [SW_W-1:0] unused_sw;

  always_comb begin
    rwx       = pte[3:1];
    is_valid  = pte[0];
    is_ptr    = is_valid && (rwx == 3'b000);
    is_leaf   = is_valid && (rwx != 3'b000);
    ppn       = pte[PTE_W-1:PPN_LO];
    low_nz    = |ppn[PPN0_W-1:0];
    flags     = pte[FLAG_W-1:0];
    unused_sw = pte[PPN_LO-1:FLAG_W];
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [IDX_W-1:0] index,
  output logic [PA_W-1:0]  addr
);
  always_comb begin
    addr = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(index) << ENT_SH);
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_is_ptr,
  output walk_state_e state_q
);
  walk_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (req_valid)     state_d = S_L1_REQ;
      S_L1_REQ:  if (mem_req_ready) state_d = S_L1_WAIT;
      S_L1_WAIT: if (mem_rsp_valid) state_d = pte_is_ptr ? S_L2_REQ : S_RESP;
      S_L2_REQ:  if (mem_req_ready) state_d = S_L2_WAIT;
      S_L2_WAIT: if (mem_rsp_valid) state_d = S_RESP;
      S_RESP:                       state_d = S_IDLE;
      default:                      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pt_walker2.sv
module pt_walker2
  import ptw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [PPN_W-1:0]    root_ppn,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [PTE_W-1:0]    mem_rsp_data,
  output logic                resp_valid,
  output logic [PPN_W-1:0]    resp_ppn,
  output logic [FLAG_W-1:0]   resp_flags,
  output logic                resp_super,
  output logic                resp_fault
);
  walk_state_e state_q;

  logic [IDX_W-1:0]  vpn1_q, vpn0_q;
  logic [PPN_W-1:0]  base_q, base_d;
  logic              base_en;
  logic [PPN_W-1:0]  res_ppn_q, res_ppn_d;
  logic [FLAG_W-1:0] res_flags_q, res_flags_d;
  logic              res_super_q, res_super_d, res_fault_q, res_fault_d;
  logic              res_en, accept, rsp_take, at_l1;

  logic              pte_v, pte_ptr, pte_leaf, pte_low_nz;
  logic [PPN_W-1:0]  pte_ppn;
  logic [FLAG_W-1:0] pte_flags;
  logic [OFF_W-1:0]  unused_offset;

  ptw_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .mem_req_ready, .mem_rsp_valid,
    .pte_is_ptr (pte_ptr),
    .state_q    (state_q)
  );

  ptw_pte_decode u_dec (
    .pte (mem_rsp_data), .is_valid (pte_v), .is_ptr (pte_ptr),
    .is_leaf (pte_leaf), .low_nz (pte_low_nz), .ppn (pte_ppn), .flags (pte_flags)
  );

  ptw_addr_gen u_agen (
    .base_ppn (base_q),
    .index    ((state_q == S_L1_REQ) ? vpn1_q : vpn0_q),
    .addr     (mem_req_addr)
  );

  // handshake decodes
  always_comb begin
    req_ready     = (state_q == S_IDLE);
    mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
    mem_rsp_ready = (state_q == S_L1_WAIT) || (state_q == S_L2_WAIT);
    resp_valid    = (state_q == S_RESP);
    accept        = req_valid && req_ready;
    rsp_take      = mem_rsp_valid && mem_rsp_ready;
    at_l1         = (state_q == S_L1_WAIT);
    unused_offset = req_vaddr[OFF_W-1:0];
  end

  // next values of table base and result
  always_comb begin
    base_en = accept || (rsp_take && at_l1 && pte_ptr);
    base_d  = accept ? root_ppn : pte_ppn;

    res_en      = rsp_take && !(at_l1 && pte_ptr);
    res_fault_d = !pte_v || (at_l1 ? (pte_leaf && pte_low_nz) : pte_ptr);
    res_super_d = !res_fault_d && at_l1;
    res_flags_d = res_fault_d ? '0 : pte_flags;
    if (res_fault_d)
      res_ppn_d = '0;
    else if (at_l1)
      res_ppn_d = {pte_ppn[PPN_W-1:PPN0_W], vpn0_q};
    else
      res_ppn_d = pte_ppn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn1_q <= '0;
      vpn0_q <= '0;
    end else if (accept) begin
      vpn1_q <= req_vaddr[VA_W-1:VA_W-IDX_W];
      vpn0_q <= req_vaddr[OFF_W+IDX_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ppn_q   <= '0;
      res_flags_q <= '0;
      res_super_q <= 1'b0;
      res_fault_q <= 1'b0;
    end else if (res_en) begin
      res_ppn_q   <= res_ppn_d;
      res_flags_q <= res_flags_d;
      res_super_q <= res_super_d;
      res_fault_q <= res_fault_d;
    end
  end

  assign resp_ppn   = res_ppn_q;
  assign resp_flags = res_flags_q;
  assign resp_super = res_super_q;
  assign resp_fault = res_fault_q;

  // assertions
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_idle_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> req_ready);
  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);
  p_issue_then_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> mem_rsp_ready);
  p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_ppn == '0 && resp_flags == '0 && !resp_super));
  p_super_leaf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_super) |-> (resp_flags[0] && resp_flags[3:1] != 3'b000));
endmodule

// File: tb/pt_walker2_bench.sv
module pt_walker2_bench;
  import ptw_pkg::*;

  typedef struct {
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
    logic              sup;
    logic              fault;
    string             tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, mem_req_valid, mem_req_ready;
  logic mem_rsp_valid, mem_rsp_ready, resp_valid, resp_super, resp_fault;
  logic [VA_W-1:0]   req_vaddr;
  logic [PPN_W-1:0]  root_ppn, resp_ppn;
  logic [PA_W-1:0]   mem_req_addr;
  logic [PTE_W-1:0]  mem_rsp_data;
  logic [FLAG_W-1:0] resp_flags;

  int checks = 0, errors = 0, resp_seen = 0, issued = 0;
  int lat = 1, cnt = 0, cyc = 0;
  bit stall = 0;
  logic [PA_W-1:0]  pend_addr;
  logic [PTE_W-1:0] mem_img [logic [PA_W-1:0]];
  item_t exp_q[$];

  always #4 clk = ~clk;

  pt_walker2 u_pt_walker2 (.*);

  function automatic logic [PTE_W-1:0] rd(input logic [PA_W-1:0] a);
    return mem_img.exists(a) ? mem_img[a] : '0;
  endfunction

  function automatic logic [PTE_W-1:0] mk(input logic [PPN_W-1:0] p, input logic [7:0] f);
    return {p, 2'b00, f};
  endfunction

  function automatic logic [PA_W-1:0] ent(input logic [PPN_W-1:0] p, input logic [IDX_W-1:0] i);
    return {p, {OFF_W{1'b0}}} + (PA_W'(i) << 2);
  endfunction

  // reference model built from R2..R8
  function automatic item_t model(input logic [31:0] va, input logic [PPN_W-1:0] rt, input string tag);
    item_t it;
    logic [PTE_W-1:0] e1, e2;
    it.ppn = '0; it.flags = '0; it.sup = 0; it.fault = 1; it.tag = tag;
    e1 = rd(ent(rt, va[31:22]));
    if (e1[0]) begin
      if (e1[3:1] == 3'b000) begin
        e2 = rd(ent(e1[31:10], va[21:12]));
        if (e2[0] && e2[3:1] != 3'b000) begin
          it.fault = 0; it.ppn = e2[31:10]; it.flags = e2[7:0];
        end
      end else if (e1[19:10] == '0) begin
        it.fault = 0; it.sup = 1; it.ppn = {e1[31:20], va[21:12]}; it.flags = e1[7:0];
      end
    end
    return it;
  endfunction

  // memory model
  initial begin
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend_addr);
        end
      end
      mem_req_ready = stall ? ((cyc % 3) == 2) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend_addr = mem_req_addr;
        cnt = lat;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && resp_valid) begin
        item_t e;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: unexpected response ppn=%h expected none", resp_ppn);
        end else begin
          e = exp_q.pop_front();
          if (resp_ppn !== e.ppn || resp_flags !== e.flags ||
              resp_super !== e.sup || resp_fault !== e.fault) begin
            errors++;
            $display("FAIL %s: ppn=%h flags=%h super=%b fault=%b expected ppn=%h flags=%h super=%b fault=%b",
                     e.tag, resp_ppn, resp_flags, resp_super, resp_fault,
                     e.ppn, e.flags, e.sup, e.fault);
          end
        end
        resp_seen++;
      end
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [PPN_W-1:0] rt,
                      input bit hammer, input string tag);
    int seen0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready before request", int'(req_ready), 1);
    exp_q.push_back(model(va, rt, tag));
    req_valid = 1'b1; req_vaddr = va; root_ppn = rt;
    seen0 = resp_seen; issued++;
    @(negedge clk);
    chk(req_ready === 1'b0, "R9 busy after accept", int'(req_ready), 0);
    if (hammer) begin
      req_vaddr = ~va; root_ppn = ~rt;
    end else begin
      req_valid = 1'b0;
    end
    while (resp_seen == seen0) @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_vaddr = '0; root_ppn = '0; rst_n = 1'b0;
    // page table image: root 0x00100
    mem_img[ent(22'h00100, 10'h048)] = mk(22'h00200, 8'h01);            // pointer
    mem_img[ent(22'h00200, 10'h345)] = mk(22'h3ABCD, 8'hC7);            // 4K leaf
    mem_img[ent(22'h00200, 10'h001)] = mk(22'h00300, 8'h01);            // pointer at L2
    mem_img[ent(22'h00100, 10'h0A0)] = mk({12'hABC, 10'h000}, 8'h19);   // superpage
    mem_img[ent(22'h00100, 10'h0A1)] = mk({12'h123, 10'h004}, 8'h0B);   // misaligned
    for (int i = 0; i < 8; i++) begin
      mem_img[ent(22'h00100, 10'(i))] = mk(22'h00400 + 22'(i), 8'h01);
      for (int j = 0; j < 16; j++)
        mem_img[ent(22'h00400 + 22'(i), 10'(j))] =
          mk(22'($urandom), 8'($urandom) | 8'h01);
    end
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 req_ready in reset", int'(req_ready), 1);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid in reset", int'(mem_req_valid), 0);
    chk(resp_valid === 1'b0, "R1 resp_valid in reset", int'(resp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_req_valid === 1'b0, "R1 idle after reset",
        int'(req_ready), 1);

    walk({10'h048, 10'h345, 12'h678}, 22'h00100, 0, "R2 R3 R4 two-level leaf");
    walk({10'h0A0, 10'h155, 12'h000}, 22'h00100, 0, "R5 superpage");
    walk({10'h0A1, 10'h155, 12'h000}, 22'h00100, 0, "R6 misaligned superpage");
    walk({10'h3FF, 10'h000, 12'h000}, 22'h00100, 0, "R7 invalid first level");
    walk({10'h048, 10'h222, 12'h000}, 22'h00100, 0, "R7 invalid second level");
    walk({10'h048, 10'h001, 12'h000}, 22'h00100, 0, "R8 pointer at second level");
    walk({10'h048, 10'h345, 12'hFFF}, 22'h00200, 0, "R2 other root");

    stall = 1; lat = 3;
    walk({10'h048, 10'h345, 12'h678}, 22'h00100, 1, "R9 R10 R11 busy and stalled");
    walk({10'h0A0, 10'h3FF, 12'h000}, 22'h00100, 1, "R9 R5 stalled superpage");

    for (int k = 0; k < 24; k++) begin
      stall = k[0]; lat = 1 + (k % 4);
      walk({10'($urandom_range(0, 9)), 10'($urandom_range(0, 23)), 12'($urandom)},
           22'h00100, k[1], "R4 R7 R8 random walk");
    end

    repeat (5) @(negedge clk);
    chk(resp_seen == issued && exp_q.size() == 0, "R10 one response per request",
        resp_seen, issued);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule